// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block is a small fetch-and-apply engine. Software places a list of register-write instructions in memory, programs a start byte address and an end byte address, and the engine walks the list one 32-bit word at a time, turning each instruction into write transactions on a register bus. It never reads registers. A busy flag stays up from the moment execution is triggered until the fetch position meets the end address.

Two instruction formats exist, both starting on an even word. A direct write is two words: the data, then a command word holding the opcode, byte enables and a register offset. An indexed burst names a word count and one register offset, then supplies that many data words, all written to the same offset. When the burst leaves the list on an odd word, one filler word follows and is skipped. An all-zero command is a no-op pair, so zero filler up to a rounded end address is consumed harmlessly. Any other opcode halts execution and raises a sticky error flag.

Three configuration registers are reached through a select code: control/status, start address and end address. Writing the end address while enabled and idle starts a run. While a run is active, every configuration write is dropped.

Top module: `cmd_stream_exec`

## Requirements
- R1: After reset the control/status register (select 0) reads 0, the start (select 1) and end (select 2) address registers read 0, and neither `memReq` nor `regWrValid` is high.
- R2: A command word with bits 31:24 equal to 0x01 yields one register write whose data is the preceding word, whose offset is command bits 19:0 and whose byte enables are command bits 23:20.
- R3: A command word with opcode 0x09 takes the count N from the low CNT_W bits of the preceding word and yields N writes of the following N data words, in order, all to command bits 19:0 with byte enables 4'hF; N equal to 0 yields no write.
- R4: When an indexed burst ends on an odd word index, the next word is skipped whatever its value, and decoding resumes at the next even word.
- R5: A command word with opcode 0x00 is a no-op pair; a list padded with zero words up to a 64-byte-aligned end address finishes with no extra write and no error.
- R6: Any other opcode stops the run at once: busy (bit 1 of select 0) clears, the error flag (bit 2 of select 0) sets and stays set, and no later instruction is applied; the flag clears when the next run starts.
- R7: Writing select 2 while bit 0 of select 0 (enable) is 1 and the engine is idle starts fetching at the start address; busy reads 1 from the next cycle until the fetch position equals the end address. With enable 0 the same write starts nothing.
- R8: Only write transactions appear on the register port; `regWrValid` is high for one cycle per write and address, data and byte enables hold steady until `regWrReady` is seen.
- R9: At most one memory word request is outstanding; each request is a one-cycle `memReq` pulse at a byte address that advances by 4, so a list of L words costs exactly L requests.
- R10: While busy, writes to the enable bit, the start address and the end address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 control/status, 1 start address, 2 end address |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Read data of the selected register |
| memReq | output | 1 | One-cycle word fetch request |
| memAddr | output | AW | Byte address of the requested word |
| memRdValid | input | 1 | Fetched word is present |
| memRdData | input | 32 | Fetched word |
| regWrValid | output | 1 | One-cycle register write request |
| regWrAddr | output | RA_W | Register offset |
| regWrData | output | 32 | Register write data |
| regWrBe | output | 4 | Byte enables |
| regWrReady | input | 1 | Register write accepted |

## Verification
The checker watches on every cycle that register writes and memory fetches appear only while busy, that each valid or request lasts a single cycle, that write fields stay frozen until acceptance, that no fetch overlaps a pending write, and that the error flag only rises together with busy dropping. Decoding itself is shown only by the bench's scenarios: the exact data, offset and byte-enable values of direct writes, burst ordering, filler skipping, zero padding, halting on a bad opcode, the fetch count and the dropping of configuration writes during a run.

// File: rtl/cse_pkg.sv
package cse_pkg;

  typedef enum logic [1:0] {PH_W0, PH_W1, PH_DATA, PH_PAD} phase_t;

  typedef enum logic [2:0] {ST_IDLE, ST_RUN, ST_WAIT, ST_ISSUE, ST_HOLD} state_t;

  localparam logic [7:0] OP_NOP     = 8'h00;
  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HEAD = 2'd1;
  localparam logic [1:0] SEL_TAIL = 2'd2;

  typedef struct packed {
    logic startRun;
    logic advPtr;
    logic capWord0;
    logic capIndexed;
    logic loadDirect;
    logic loadData;
    logic decCount;
    logic setErr;
  } strobe_t;

endpackage

// File: rtl/cse_dpath.sv
module cse_dpath
  import cse_pkg::*;
#(
  parameter int AW    = 32,
  parameter int RA_W  = 20,
  parameter int CNT_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic            busy,
  input  logic            cfgWe,
  input  logic [1:0]      cfgSel,
  input  logic [31:0]     cfgWdata,
  output logic [31:0]     cfgRdata,
  input  logic [31:0]     memRdData,
  output logic [AW-1:0]   memAddr,
  output logic            enable,
  output logic            errFlag,
  output logic            atTail,
  output logic            ptrOdd,
  output logic            word0CntZero,
  output logic            countIsOne,
  output logic [7:0]      opcode,
  output logic [RA_W-1:0] regWrAddr,
  output logic [31:0]     regWrData,
  output logic [3:0]      regWrBe
);

  localparam logic [AW-1:0]    WORD_STEP = AW'(4);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  logic [AW-1:0]    headPtr, tailPtr, fetchPtr;
  logic [31:0]      word0;
  logic [RA_W-1:0]  burstAddr;
  logic [CNT_W-1:0] burstLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      errFlag   <= 1'b0;
      headPtr   <= '0;
      tailPtr   <= '0;
      fetchPtr  <= '0;
      word0     <= '0;
      burstAddr <= '0;
      burstLeft <= '0;
      regWrAddr <= '0;
      regWrData <= '0;
      regWrBe   <= '0;
    end else begin
      if (cfgWe && !busy) begin
        unique case (cfgSel)
          SEL_CTRL: enable  <= cfgWdata[0];
          SEL_HEAD: headPtr <= cfgWdata[AW-1:0];
          SEL_TAIL: tailPtr <= cfgWdata[AW-1:0];
          default: ;
        endcase
      end
      if (strb.startRun) begin
        fetchPtr <= headPtr;
        errFlag  <= 1'b0;
      end
      if (strb.advPtr)   fetchPtr <= fetchPtr + WORD_STEP;
      if (strb.capWord0) word0    <= memRdData;
      if (strb.capIndexed) begin
        burstAddr <= memRdData[RA_W-1:0];
        burstLeft <= word0[CNT_W-1:0];
      end
      if (strb.loadDirect) begin
        regWrAddr <= memRdData[RA_W-1:0];
        regWrBe   <= memRdData[23:20];
        regWrData <= word0;
      end
      if (strb.loadData) begin
        regWrAddr <= burstAddr;
        regWrBe   <= 4'hF;
        regWrData <= memRdData;
      end
      if (strb.decCount) burstLeft <= burstLeft - CNT_ONE;
      if (strb.setErr)   errFlag   <= 1'b1;
    end
  end

  assign memAddr      = fetchPtr;
  assign atTail       = (fetchPtr == tailPtr);
  assign ptrOdd       = fetchPtr[2];
  assign word0CntZero = (word0[CNT_W-1:0] == '0);
  assign countIsOne   = (burstLeft == CNT_ONE);
  assign opcode       = memRdData[31:24];

  always_comb begin
    unique case (cfgSel)
      SEL_CTRL: cfgRdata = {29'd0, errFlag, busy, enable};
      SEL_HEAD: cfgRdata = 32'(headPtr);
      SEL_TAIL: cfgRdata = 32'(tailPtr);
      default:  cfgRdata = '0;
    endcase
  end

endmodule

// File: rtl/cse_ctrl.sv
module cse_ctrl
  import cse_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [1:0] cfgSel,
  input  logic       enable,
  input  logic       atTail,
  input  logic       ptrOdd,
  input  logic       word0CntZero,
  input  logic       countIsOne,
  input  logic [7:0] opcode,
  input  logic       memRdValid,
  input  logic       regWrReady,
  output strobe_t    strb,
  output logic       busy,
  output logic       memReq,
  output logic       regWrValid
);

  state_t stateQ, stateD;
  phase_t phaseQ, phaseD;
  logic   wrDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      phaseQ <= PH_W0;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
    end
  end

  assign busy       = (stateQ != ST_IDLE);
  assign memReq     = (stateQ == ST_RUN) && !atTail;
  assign regWrValid = (stateQ == ST_ISSUE);
  assign wrDone     = ((stateQ == ST_ISSUE) || (stateQ == ST_HOLD)) && regWrReady;

  always_comb begin
    stateD = stateQ;
    phaseD = phaseQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cfgWe && (cfgSel == SEL_TAIL) && enable) begin
          strb.startRun = 1'b1;
          stateD        = ST_RUN;
          phaseD        = PH_W0;
        end
      end
      ST_RUN: begin
        stateD = atTail ? ST_IDLE : ST_WAIT;
      end
      ST_WAIT: begin
        if (memRdValid) begin
          strb.advPtr = 1'b1;
          stateD      = ST_RUN;
          unique case (phaseQ)
            PH_W0: begin
              strb.capWord0 = 1'b1;
              phaseD        = PH_W1;
            end
            PH_W1: begin
              phaseD = PH_W0;
              if (opcode == OP_DIRECT) begin
                strb.loadDirect = 1'b1;
                stateD          = ST_ISSUE;
              end else if (opcode == OP_INDEXED) begin
                strb.capIndexed = 1'b1;
                if (!word0CntZero) phaseD = PH_DATA;
              end else if (opcode != OP_NOP) begin
                strb.setErr = 1'b1;
                stateD      = ST_IDLE;
              end
            end
            PH_DATA: begin
              strb.loadData = 1'b1;
              stateD        = ST_ISSUE;
            end
            default: phaseD = PH_W0;
          endcase
        end
      end
      ST_ISSUE, ST_HOLD: begin
        if (wrDone) begin
          stateD = ST_RUN;
          if (phaseQ == PH_DATA) begin
            strb.decCount = 1'b1;
            if (countIsOne) phaseD = ptrOdd ? PH_PAD : PH_W0;
          end
        end else begin
          stateD = ST_HOLD;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/cmd_stream_exec.sv
module cmd_stream_exec
  import cse_pkg::*;
#(
  parameter int AW    = 32,
  parameter int RA_W  = 20,
  parameter int CNT_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [1:0]      cfgSel,
  input  logic [31:0]     cfgWdata,
  output logic [31:0]     cfgRdata,
  output logic            memReq,
  output logic [AW-1:0]   memAddr,
  input  logic            memRdValid,
  input  logic [31:0]     memRdData,
  output logic            regWrValid,
  output logic [RA_W-1:0] regWrAddr,
  output logic [31:0]     regWrData,
  output logic [3:0]      regWrBe,
  input  logic            regWrReady
);

  strobe_t    strb;
  logic       busyW, errW, enableW;
  logic       atTailW, ptrOddW, cntZeroW, cntOneW;
  logic [7:0] opcodeW;

  cse_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWe        (cfgWe),
    .cfgSel       (cfgSel),
    .enable       (enableW),
    .atTail       (atTailW),
    .ptrOdd       (ptrOddW),
    .word0CntZero (cntZeroW),
    .countIsOne   (cntOneW),
    .opcode       (opcodeW),
    .memRdValid   (memRdValid),
    .regWrReady   (regWrReady),
    .strb         (strb),
    .busy         (busyW),
    .memReq       (memReq),
    .regWrValid   (regWrValid)
  );

  cse_dpath #(.AW(AW), .RA_W(RA_W), .CNT_W(CNT_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busy         (busyW),
    .cfgWe        (cfgWe),
    .cfgSel       (cfgSel),
    .cfgWdata     (cfgWdata),
    .cfgRdata     (cfgRdata),
    .memRdData    (memRdData),
    .memAddr      (memAddr),
    .enable       (enableW),
    .errFlag      (errW),
    .atTail       (atTailW),
    .ptrOdd       (ptrOddW),
    .word0CntZero (cntZeroW),
    .countIsOne   (cntOneW),
    .opcode       (opcodeW),
    .regWrAddr    (regWrAddr),
    .regWrData    (regWrData),
    .regWrBe      (regWrBe)
  );

endmodule

// File: rtl/cse_checker.sv
module cse_checker #(
  parameter int RA_W = 20
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            err,
  input logic            memReq,
  input logic            regWrValid,
  input logic            regWrReady,
  input logic [RA_W-1:0] regWrAddr,
  input logic [31:0]     regWrData,
  input logic [3:0]      regWrBe
);

  logic pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          pending <= 1'b0;
    else if (regWrReady)                pending <= 1'b0;
    else if (regWrValid)                pending <= 1'b1;
  end

  a_r8_write_in_run: assert property (@(posedge clk) disable iff (!rstN)
    regWrValid |-> busy);

  a_r8_single_valid: assert property (@(posedge clk) disable iff (!rstN)
    regWrValid |=> !regWrValid);

  a_r8_hold_fields: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> ($stable(regWrAddr) && $stable(regWrData) && $stable(regWrBe)));

  a_r9_req_in_run: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  a_r9_no_fetch_while_writing: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !memReq);

  a_r6_error_halts: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> !busy);

endmodule

bind cmd_stream_exec cse_checker #(.RA_W(RA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busyW),
  .err        (errW),
  .memReq     (memReq),
  .regWrValid (regWrValid),
  .regWrReady (regWrReady),
  .regWrAddr  (regWrAddr),
  .regWrData  (regWrData),
  .regWrBe    (regWrBe)
);

// File: tb/cmd_stream_exec_bench.sv
module cmd_stream_exec_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        regWrValid;
  logic [19:0] regWrAddr;
  logic [31:0] regWrData;
  logic [3:0]  regWrBe;
  logic        regWrReady = 1'b0;

  always #10 clk = ~clk;

  cmd_stream_exec u_cmd_stream_exec (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .memReq(memReq), .memAddr(memAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .regWrValid(regWrValid), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regWrBe(regWrBe), .regWrReady(regWrReady)
  );

  int checks = 0;
  int failures = 0;

  logic [31:0] mem [0:255];
  int          nreq = 0;
  int          nwr = 0;
  int          lagCfg = 0;
  int          lagCnt = 0;
  logic        pendW = 1'b0;
  logic [19:0] logAddr [0:31];
  logic [31:0] logData [0:31];
  logic [3:0]  logBe   [0:31];

  // memory model: word returned one cycle after the request
  always @(posedge clk) begin
    memRdValid <= 1'b0;
    if (memReq) begin
      memRdValid <= 1'b1;
      memRdData  <= mem[memAddr[9:2]];
      nreq       <= nreq + 1;
    end
  end

  // register slave: accepts after lagCfg extra cycles, logs accepted writes
  always @(posedge clk) begin
    regWrReady <= 1'b0;
    if (regWrValid) begin
      pendW  <= 1'b1;
      lagCnt <= lagCfg;
    end else if (pendW && !regWrReady) begin
      if (lagCnt == 0) regWrReady <= 1'b1;
      else lagCnt <= lagCnt - 1;
    end
    if (regWrReady) begin
      pendW <= 1'b0;
      if (nwr < 32) begin
        logAddr[nwr] <= regWrAddr;
        logData[nwr] <= regWrData;
        logBe[nwr]   <= regWrBe;
      end
      nwr <= nwr + 1;
    end
  end

  localparam logic [55:0] VEC [0:5] = '{
    {4'hF, 20'h00010, 32'h1234_5678},
    {4'h1, 20'hFFFFF, 32'hA5A5_A5A5},
    {4'h3, 20'h00000, 32'h0000_0000},
    {4'hC, 20'h8_0004, 32'hFFFF_FFFF},
    {4'h0, 20'h1_2340, 32'h0BAD_F00D},
    {4'h6, 20'h0_0FF8, 32'h8000_0001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfgSel = s; cfgWdata = d; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input logic [1:0] s, output logic [31:0] d);
    cfgSel = s;
    #1;
    d = cfgRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cfgRead(2'd0, v);
      if (!v[1]) break;
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
  endtask

  task automatic clearLog();
    @(negedge clk);
    nwr = 0; nreq = 0;
  endtask

  task automatic startRun(input logic [31:0] h, input logic [31:0] t);
    cfgWrite(2'd0, 32'd1);
    cfgWrite(2'd1, h);
    cfgWrite(2'd2, t);
  endtask

  task automatic loadBurst3();
    mem[16] = 32'd3;
    mem[17] = {8'h09, 4'h0, 20'h0ABCD};
    mem[18] = 32'h1111_0001;
    mem[19] = 32'h2222_0002;
    mem[20] = 32'h3333_0003;
    mem[21] = 32'hDEAD_BEEF;
    mem[22] = 32'h0000_0055;
    mem[23] = {8'h01, 4'h3, 20'h00123};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    clearMem();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    cfgRead(2'd0, v); chk("R1 ctrl", v, 32'd0);
    cfgRead(2'd1, v); chk("R1 head", v, 32'd0);
    cfgRead(2'd2, v); chk("R1 tail", v, 32'd0);
    chk("R1 memReq", {31'd0, memReq}, 32'd0);
    chk("R1 regWrValid", {31'd0, regWrValid}, 32'd0);

    // R2: direct writes from the vector table
    for (int i = 0; i < 6; i++) begin
      clearMem();
      mem[0] = VEC[i][31:0];
      mem[1] = {8'h01, VEC[i][55:52], VEC[i][51:32]};
      lagCfg = i % 3;
      clearLog();
      startRun(32'd0, 32'd8);
      if (i == 0) begin
        cfgRead(2'd0, v);
        chk("R7 busy after start", {31'd0, v[1]}, 32'd1);
      end
      waitIdle();
      chk("R2 write count", nwr, 32'd1);
      chk("R2 offset", {12'd0, logAddr[0]}, {12'd0, VEC[i][51:32]});
      chk("R2 data", logData[0], VEC[i][31:0]);
      chk("R2 byte enables", {28'd0, logBe[0]}, {28'd0, VEC[i][55:52]});
    end

    // R3/R4/R9: odd burst with junk filler, then a direct write
    clearMem();
    loadBurst3();
    lagCfg = 2;
    clearLog();
    startRun(32'h40, 32'h60);
    waitIdle();
    chk("R4 write count", nwr, 32'd4);
    chk("R3 burst offset 0", {12'd0, logAddr[0]}, 32'h0000_ABCD);
    chk("R3 burst offset 2", {12'd0, logAddr[2]}, 32'h0000_ABCD);
    chk("R3 burst data 0", logData[0], 32'h1111_0001);
    chk("R3 burst data 1", logData[1], 32'h2222_0002);
    chk("R3 burst data 2", logData[2], 32'h3333_0003);
    chk("R3 burst be", {28'd0, logBe[1]}, 32'h0000_000F);
    chk("R4 after pad offset", {12'd0, logAddr[3]}, 32'h0000_0123);
    chk("R4 after pad data", logData[3], 32'h0000_0055);
    chk("R9 fetch count", nreq, 32'd8);

    // R3: even burst and empty burst
    clearMem();
    mem[0] = 32'd2; mem[1] = {8'h09, 4'h0, 20'h00777};
    mem[2] = 32'd11; mem[3] = 32'd22;
    mem[4] = 32'd0; mem[5] = {8'h09, 4'h0, 20'h00888};
    mem[6] = 32'd7; mem[7] = {8'h01, 4'hF, 20'h00999};
    lagCfg = 0;
    clearLog();
    startRun(32'd0, 32'd32);
    waitIdle();
    chk("R3 even/empty count", nwr, 32'd3);
    chk("R3 even data 1", logData[1], 32'd22);
    chk("R3 empty burst skipped", {12'd0, logAddr[2]}, 32'h0000_0999);

    // R6: bad opcode halts
    clearMem();
    mem[0] = 32'd1; mem[1] = {8'h05, 4'hF, 20'h00010};
    mem[2] = 32'd9; mem[3] = {8'h01, 4'hF, 20'h00011};
    clearLog();
    startRun(32'd0, 32'd16);
    waitIdle();
    cfgRead(2'd0, v);
    chk("R6 error set", {31'd0, v[2]}, 32'd1);
    chk("R6 busy clear", {31'd0, v[1]}, 32'd0);
    chk("R6 no writes", nwr, 32'd0);
    repeat (5) @(negedge clk);
    cfgRead(2'd0, v);
    chk("R6 error sticky", {31'd0, v[2]}, 32'd1);

    // R5: zero filler up to a 64-byte end; also clears the error (R6)
    clearMem();
    mem[0] = 32'h0000_CAFE; mem[1] = {8'h01, 4'hF, 20'h00042};
    clearLog();
    startRun(32'd0, 32'd64);
    waitIdle();
    cfgRead(2'd0, v);
    chk("R5 single write", nwr, 32'd1);
    chk("R5 no error", {31'd0, v[2]}, 32'd0);
    chk("R6 error cleared by start", {31'd0, v[2]}, 32'd0);
    chk("R5 fetched all filler", nreq, 32'd16);

    // R10: configuration writes during a run are ignored
    clearMem();
    loadBurst3();
    lagCfg = 30;
    clearLog();
    startRun(32'h40, 32'h60);
    cfgWrite(2'd1, 32'h100);
    cfgWrite(2'd0, 32'd0);
    cfgWrite(2'd2, 32'h200);
    waitIdle();
    cfgRead(2'd1, v); chk("R10 head kept", v, 32'h40);
    cfgRead(2'd2, v); chk("R10 tail kept", v, 32'h60);
    cfgRead(2'd0, v); chk("R10 enable kept", {31'd0, v[0]}, 32'd1);
    chk("R10 run completed", nwr, 32'd4);

    // R7: end-address write while disabled starts nothing
    clearMem();
    mem[0] = 32'd5; mem[1] = {8'h01, 4'hF, 20'h00050};
    lagCfg = 0;
    clearLog();
    cfgWrite(2'd0, 32'd0);
    cfgWrite(2'd1, 32'd0);
    cfgWrite(2'd2, 32'd64);
    cfgRead(2'd0, v);
    chk("R7 disabled no busy", {31'd0, v[1]}, 32'd0);
    repeat (50) @(negedge clk);
    chk("R7 disabled no fetch", nreq, 32'd0);
    chk("R7 disabled no write", nwr, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule